// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the serial test port of a chip. It runs the sixteen-state test controller from the test clock and the mode-select pin. It holds a three-bit instruction and decodes it into a choice of shift path plus three control requests. The shift path is one of three: a one-bit bypass stage, a 32-bit identification word, or an external boundary-scan chain. The chain's cells sit outside this block. The controller reaches them through capture, shift and update strobes and reads them back through a serial return input.

The control requests go to the rest of the chip. The first asks for functional reset. The second asks for every pin to go high impedance. The third makes the outputs follow the boundary update latches. The serial pins have no valid/ready handshake. Each bit moves on a test clock edge, the chip cannot stall the port, and the only flow control is the state sequence driven on the mode-select pin. A new instruction takes effect on the falling clock edge while the controller sits in Update-IR. This keeps the control outputs steady for the whole of each instruction.

Top module: `tap_ctrl_top`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on rising `tck` edges. Five rising edges with `tms` high reach Test-Logic-Reset from any state. Driving `trst_n` low forces Test-Logic-Reset at once, without waiting for a clock edge.
- R2: In Test-Logic-Reset the active instruction becomes the identification code (1), and `func_rst_req`, `pin_hiz_req` and `bsr_drive` are all low.
- R3: In Capture-IR the instruction shifter loads binary 001. The shifter moves LSB first from `tdi` towards `tdo`. The shifted code becomes active on the falling `tck` edge in Update-IR, not before.
- R4: The instruction codes are: 0 drive from the boundary chain, 1 identification, 2 sample through the boundary chain, 5 high impedance, 6 clamp, 7 bypass. Codes 3 and 4 behave exactly as bypass.
- R5: When the bypass stage is the path, it loads 0 at Capture-DR. The first bit out is therefore 0, and after it comes `tdi` delayed by one shift.
- R6: With code 1 active, Capture-DR loads the word {version[3:0], design centre[5:0], device[9:0], manufacturer[10:0], 1}, bit 31 first in that list. The word then shifts out LSB first, followed by the `tdi` bits.
- R7: While code 5 is active, `pin_hiz_req` is high and the bypass stage is the path.
- R8: While code 6 is active, `func_rst_req` and `bsr_drive` are both high and the bypass stage is the path.
- R9: Codes 0 and 2 route `bsr_so` to `tdo`. `bsr_drive` is high under code 0 only.
- R10: `bsr_capture`, `bsr_shift` and `bsr_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only under codes 0 or 2.
- R11: `tdo` changes only on falling `tck` edges. `tdo_en` is high exactly when the state at the last falling edge was Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for the `tdo` pad |
| bsr_so | input | 1 | Serial return from the boundary chain |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_drive | output | 1 | Outputs follow boundary update latches |
| func_rst_req | output | 1 | Functional reset request |
| pin_hiz_req | output | 1 | All-pins high impedance request |

## Verification
The checks assume three things about the inputs. `tms` and `tdi` must be steady around each rising `tck` edge. `trst_n` must be released away from clock edges. `bsr_so` must come from a chain that changes only on rising edges. The stimulus meets all three by changing inputs one time unit after each falling edge, and the bench models the external chain as a small register clocked on the rising edge. The five-ones check counts consecutive `tms` highs in the checker instead of looking back through history. The strobe checks take the state one cycle later as the proof that the walk through the graph was legal.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAUSE_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAUSE_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_t;

  typedef struct packed {
    dr_path_t path;
    logic     func_rst;
    logic     hiz;
    logic     drive;
  } instr_ctl_t;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'd0;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'd1;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'd2;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'd5;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'd6;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'd7;

  function automatic tap_state_t tap_next(input tap_state_t st, input logic tms);
    tap_state_t nx;
    case (st)
      ST_TLR:      nx = tms ? ST_TLR    : ST_RTI;
      ST_RTI:      nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR:   nx = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR:   nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:    nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR:   nx = tms ? ST_UPD_DR : ST_PAUSE_DR;
      ST_PAUSE_DR: nx = tms ? ST_EX2_DR : ST_PAUSE_DR;
      ST_EX2_DR:   nx = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR:   nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR:   nx = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR:   nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:    nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR:   nx = tms ? ST_UPD_IR : ST_PAUSE_IR;
      ST_PAUSE_IR: nx = tms ? ST_EX2_IR : ST_PAUSE_IR;
      ST_EX2_IR:   nx = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR:   nx = tms ? ST_SEL_DR : ST_RTI;
      default:     nx = ST_TLR;
    endcase
    return nx;
  endfunction

  function automatic instr_ctl_t tap_decode(input logic [IR_W-1:0] op);
    instr_ctl_t c;
    c = '{path: PATH_BYP, func_rst: 1'b0, hiz: 1'b0, drive: 1'b0};
    case (op)
      OP_EXTEST: begin c.path = PATH_BSR; c.drive = 1'b1; end
      OP_IDCODE: c.path = PATH_ID;
      OP_SAMPLE: c.path = PATH_BSR;
      OP_HIGHZ:  c.hiz = 1'b1;
      OP_CLAMP:  begin c.func_rst = 1'b1; c.drive = 1'b1; end
      default:   c.path = PATH_BYP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter logic [IR_W-1:0] CAPTURE_PAT = 3'b001,
  parameter logic [IR_W-1:0] RESET_OP    = OP_IDCODE
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_t state,
  output logic       ir_so,
  output instr_ctl_t ctl
);

  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] act_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= CAPTURE_PAT;
    end else begin
      case (state)
        ST_CAP_IR: sh_q <= CAPTURE_PAT;
        ST_SH_IR:  sh_q <= {tdi, sh_q[IR_W-1:1]};
        default:   ;
      endcase
    end
  end

  // active instruction changes mid-cycle so controls stay flat across rising edges
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)                 act_q <= RESET_OP;
    else if (state == ST_TLR)   act_q <= RESET_OP;
    else if (state == ST_UPD_IR) act_q <= sh_q;
  end

  assign ir_so = sh_q[0];
  assign ctl   = tap_decode(act_q);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter logic [3:0]  VERSION    = 4'h1,
  parameter logic [5:0]  DESIGN_CTR = 6'h00,
  parameter logic [9:0]  DEVICE     = 10'h000,
  parameter logic [10:0] MFR_CODE   = 11'h001
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_t state,
  input  dr_path_t   path,
  input  logic       bsr_so,
  output logic       dr_so
);

  localparam logic [ID_W-1:0] ID_WORD = {VERSION, DESIGN_CTR, DEVICE, MFR_CODE, 1'b1};

  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else if (path == PATH_BYP) begin
      case (state)
        ST_CAP_DR: byp_q <= 1'b0;
        ST_SH_DR:  byp_q <= tdi;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= ID_WORD;
    end else if (path == PATH_ID) begin
      case (state)
        ST_CAP_DR: id_q <= ID_WORD;
        ST_SH_DR:  id_q <= {tdi, id_q[ID_W-1:1]};
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_so = id_q[0];
      PATH_BSR: dr_so = bsr_so;
      default:  dr_so = byp_q;
    endcase
  end

endmodule

// File: rtl/tap_ctrl_top.sv
module tap_ctrl_top
  import tap_pkg::*;
#(
  parameter bit          HAS_TRST   = 1'b1,
  parameter logic [3:0]  VERSION    = 4'h1,
  parameter logic [5:0]  DESIGN_CTR = 6'h00,
  parameter logic [9:0]  DEVICE     = 10'h000,
  parameter logic [10:0] MFR_CODE   = 11'h001
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  input  logic bsr_so,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic bsr_drive,
  output logic func_rst_req,
  output logic pin_hiz_req
);

  logic       rst_n;
  tap_state_t state;
  instr_ctl_t ctl;
  logic       ir_so;
  logic       dr_so;
  logic       bsr_sel;

  generate
    if (HAS_TRST) begin : g_trst
      assign rst_n = trst_n;
    end else begin : g_no_trst
      assign rst_n = 1'b1;
    end
  endgenerate

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck   (tck),
    .rst_n (rst_n),
    .tdi   (tdi),
    .state (state),
    .ir_so (ir_so),
    .ctl   (ctl)
  );

  tap_dr #(
    .VERSION    (VERSION),
    .DESIGN_CTR (DESIGN_CTR),
    .DEVICE     (DEVICE),
    .MFR_CODE   (MFR_CODE)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .path   (ctl.path),
    .bsr_so (bsr_so),
    .dr_so  (dr_so)
  );

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      case (state)
        ST_SH_IR: begin tdo <= ir_so; tdo_en <= 1'b1; end
        ST_SH_DR: begin tdo <= dr_so; tdo_en <= 1'b1; end
        default:  tdo_en <= 1'b0;
      endcase
    end
  end

  assign bsr_sel      = (ctl.path == PATH_BSR);
  assign bsr_capture  = bsr_sel && (state == ST_CAP_DR);
  assign bsr_shift    = bsr_sel && (state == ST_SH_DR);
  assign bsr_update   = bsr_sel && (state == ST_UPD_DR);
  assign bsr_drive    = ctl.drive;
  assign func_rst_req = ctl.func_rst;
  assign pin_hiz_req  = ctl.hiz;

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
  import tap_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input tap_state_t state,
  input logic       tdo_en,
  input logic       func_rst_req,
  input logic       pin_hiz_req,
  input logic       bsr_drive,
  input logic       bsr_capture,
  input logic       bsr_update
);

  logic [2:0] ones_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              ones_q <= 3'd0;
    else if (!tms)            ones_q <= 3'd0;
    else if (ones_q != 3'd7)  ones_q <= ones_q + 3'd1;
  end

  // R1
  five_ones_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_q >= 3'd5) |-> (state == ST_TLR));

  // R2
  tlr_clears_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && $past(state) == ST_TLR) |-> (!func_rst_req && !pin_hiz_req && !bsr_drive));

  // R8
  clamp_pair_chk: assert property (@(posedge tck) disable iff (!trst_n)
    func_rst_req |-> (bsr_drive && !pin_hiz_req));

  // R10
  capture_next_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_capture |=> (state == ST_SH_DR || state == ST_EX1_DR));

  // R10
  update_next_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_update |=> (state == ST_RTI || state == ST_SEL_DR));

  // R11
  tdo_en_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind tap_ctrl_top tap_ctrl_chk u_chk (
  .tck          (tck),
  .trst_n       (trst_n),
  .tms          (tms),
  .state        (state),
  .tdo_en       (tdo_en),
  .func_rst_req (func_rst_req),
  .pin_hiz_req  (pin_hiz_req),
  .bsr_drive    (bsr_drive),
  .bsr_capture  (bsr_capture),
  .bsr_update   (bsr_update)
);

// File: tb/tap_ctrl_top_bench.sv
`timescale 1ns/1ps
module tap_ctrl_top_bench;

  localparam logic [3:0]  P_VER = 4'h2;
  localparam logic [5:0]  P_DC  = 6'h0D;
  localparam logic [9:0]  P_DEV = 10'h155;
  localparam logic [10:0] P_MFR = 11'h0A7;
  localparam logic [31:0] ID_EXP = {P_VER, P_DC, P_DEV, P_MFR, 1'b1};

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_en, bsr_so, bsr_capture, bsr_shift, bsr_update;
  logic bsr_drive, func_rst_req, pin_hiz_req;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic exp_q[$];
  string tag_q[$];
  logic [3:0] chain = 4'h0;
  int cap_cnt = 0;
  int upd_cnt = 0;
  logic pre_hiz;
  logic pre_rst;

  always #4 tck = ~tck;

  tap_ctrl_top #(
    .HAS_TRST(1'b1), .VERSION(P_VER), .DESIGN_CTR(P_DC), .DEVICE(P_DEV), .MFR_CODE(P_MFR)
  ) u_tap_ctrl_top (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .bsr_drive(bsr_drive), .func_rst_req(func_rst_req),
    .pin_hiz_req(pin_hiz_req)
  );

  // external boundary chain model: four cells, capture value 4'hA
  always @(posedge tck) begin
    if (bsr_capture) begin
      chain <= 4'hA;
      cap_cnt <= cap_cnt + 1;
    end else if (bsr_shift) begin
      chain <= {tdi, chain[3:1]};
    end
    if (bsr_update) upd_cnt <= upd_cnt + 1;
  end
  assign bsr_so = chain[0];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    @(posedge tck);
  endtask

  task automatic push_bits(input logic [63:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v[i]);
      tag_q.push_back(tag);
    end
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic load_ir(input logic [2:0] code);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    push_bits(64'b001, 3, "R3");
    for (int i = 0; i < 3; i++) step(i == 2, code[i]);
    step(1'b1, 1'b0);
    #1;
    pre_hiz = pin_hiz_req;
    pre_rst = func_rst_req;
    step(1'b0, 1'b0);
    #1;
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, input logic [63:0] exp, input string tag);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    push_bits(exp, n, tag);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    #1;
  endtask

  // scoreboard monitor: one bit per enabled falling edge
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (tdo_en === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected tdo_en", {63'd0, tdo}, 64'd0);
        end else begin
          automatic logic e = exp_q.pop_front();
          automatic string r = tag_q.pop_front();
          check(tdo === e, r, {63'd0, tdo}, {63'd0, e});
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    int u0;
    repeat (3) @(posedge tck);
    @(negedge tck);
    #1 trst_n = 1'b1;
    #1;
    // R2 reset state
    check({func_rst_req, pin_hiz_req, bsr_drive} == 3'b000, "R2 reset controls", {61'd0, func_rst_req, pin_hiz_req, bsr_drive}, 64'd0);
    check(tdo_en == 1'b0, "R11 tdo_en in reset", {63'd0, tdo_en}, 64'd0);
    check({bsr_capture, bsr_shift, bsr_update} == 3'b000, "R10 strobes idle", {61'd0, bsr_capture, bsr_shift, bsr_update}, 64'd0);

    step(1'b0, 1'b0);
    // R6 identification word after reset, then tdi bits follow
    shift_dr(40, 64'h00000000_C5_000000 >> 24, {24'd0, 8'hC5, ID_EXP}, "R6");

    // R5 bypass
    load_ir(3'd7);
    c0 = cap_cnt;
    shift_dr(16, 64'hB38D, 64'hB38D << 1, "R5");
    check(cap_cnt == c0, "R10 no capture under bypass", cap_cnt, c0);

    // R7 / R3 high impedance
    load_ir(3'd5);
    check(pre_hiz == 1'b0, "R3 not active before falling edge", {63'd0, pre_hiz}, 64'd0);
    check(pin_hiz_req == 1'b1, "R7 hiz request", {63'd0, pin_hiz_req}, 64'd1);
    check(func_rst_req == 1'b0 && bsr_drive == 1'b0, "R7 others low", {62'd0, func_rst_req, bsr_drive}, 64'd0);
    shift_dr(8, 64'h6B, 64'h6B << 1, "R7");

    // R8 clamp
    load_ir(3'd6);
    check(pre_rst == 1'b0, "R3 clamp waits for falling edge", {63'd0, pre_rst}, 64'd0);
    check({func_rst_req, bsr_drive, pin_hiz_req} == 3'b110, "R8 clamp controls", {61'd0, func_rst_req, bsr_drive, pin_hiz_req}, 64'b110);
    shift_dr(8, 64'hD4, 64'hD4 << 1, "R8");

    // R9 drive from chain
    load_ir(3'd0);
    check({func_rst_req, bsr_drive, pin_hiz_req} == 3'b010, "R9 extest controls", {61'd0, func_rst_req, bsr_drive, pin_hiz_req}, 64'b010);
    c0 = cap_cnt;
    u0 = upd_cnt;
    shift_dr(8, 64'h3, {56'd0, 4'h3, 4'hA}, "R9");
    check(cap_cnt == c0 + 1, "R10 one capture", cap_cnt, c0 + 1);
    check(upd_cnt == u0 + 1, "R10 one update", upd_cnt, u0 + 1);

    // R9 sample through chain
    load_ir(3'd2);
    check(bsr_drive == 1'b0, "R9 sample no drive", {63'd0, bsr_drive}, 64'd0);
    shift_dr(8, 64'hC, {56'd0, 4'hC, 4'hA}, "R9");

    // R4 undefined codes
    load_ir(3'd3);
    check({func_rst_req, bsr_drive, pin_hiz_req} == 3'b000, "R4 code 3 controls", {61'd0, func_rst_req, bsr_drive, pin_hiz_req}, 64'd0);
    c0 = cap_cnt;
    shift_dr(8, 64'h9A, 64'h9A << 1, "R4");
    check(cap_cnt == c0, "R4 code 3 no capture", cap_cnt, c0);
    load_ir(3'd4);
    shift_dr(8, 64'h57, 64'h57 << 1, "R4");

    // R1 / R2 five ones back to reset
    load_ir(3'd6);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    @(negedge tck);
    #1;
    check({func_rst_req, bsr_drive} == 2'b00, "R1 five ones clears clamp", {62'd0, func_rst_req, bsr_drive}, 64'd0);
    step(1'b0, 1'b0);
    shift_dr(32, 64'd0, {32'd0, ID_EXP}, "R2");

    // R1 asynchronous reset
    load_ir(3'd5);
    @(negedge tck);
    #3 trst_n = 1'b0;
    #1;
    check(pin_hiz_req == 1'b0, "R1 async reset", {63'd0, pin_hiz_req}, 64'd0);
    @(negedge tck);
    #1 trst_n = 1'b1;
    step(1'b0, 1'b0);
    shift_dr(32, 64'd0, {32'd0, ID_EXP}, "R1");

    repeat (2) @(posedge tck);
    check(exp_q.size() == 0, "R11 all bits seen", exp_q.size(), 64'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule